// File: doc/BRIEF.md
# Phase-Synchronized PWM Time Base

This block is an up-counting PWM time base with two compare channels. It produces two raw PWM waveforms, a counter-zero event and a sync output. Software programs it through a simple write port that holds five registers: period, compare A, compare B, phase and mode. Period and compare writes normally land in shadow copies. These copies become active only when the counter is at zero, so a frequency or duty change never cuts a PWM cycle short.

Several instances can form a phase-shifted chain. The master sends a one-clock pulse at each counter zero. Each slave either forwards the pulse it receives or regenerates its own, and reloads its counter with its programmed phase value. Per-register immediate-mode bits let software skip the shadow copy when it needs to. The time base runs at the undivided input clock.

Top module: `pwm_phase_timebase`

## Requirements
- R1: The counter steps up by one each clock from 0 and wraps to 0 after it reaches the active period P, so one PWM cycle lasts P+1 clocks. `zero_evt` is high exactly while the counter is 0.
- R2: With mode bit 2 clear, a write to address 0 (period) goes to a shadow copy. The shadow is moved into the active period on the clock edge where the counter is 0, so the cycle in progress keeps its old length.
- R3: With mode bits 3 and 4 clear, writes to address 1 (compare A) and address 2 (compare B) go to shadow copies. These load into the active compare values on the clock edge where the counter is 0.
- R4: Mode bit 2 (period), bit 3 (compare A) and bit 4 (compare B) each select immediate mode for their register. In immediate mode a write updates the active value on the same clock edge, and the change is visible in the current cycle.
- R5: `pwm_a` is set on the edge where the counter is 0 and cleared on the edge where the counter equals active compare A. Over any P+1 consecutive clocks in steady state it is high for min(A, P+1) clocks. `pwm_b` behaves the same way against compare B.
- R6: When the zero set and a compare clear fall on the same edge, the clear wins. A compare value of 0 keeps the output low, and a compare value above P keeps it high.
- R7: With mode bit 1 clear (master), `sync_out` equals `zero_evt`: one pulse per cycle, at counter zero.
- R8: With mode bit 1 set (forwarding), `sync_out` follows `sync_in` combinationally and does not pulse at counter zero.
- R9: With mode bit 0 set, a clock edge with `sync_in` high loads the counter with the phase register (address 3). Counting then continues from that value.
- R10: With mode bit 0 clear, `sync_in` has no effect on the counter.
- R11: If the counter is at or above the active period on an edge (after an immediate period shrink or a phase load), the counter goes to 0 on that edge.
- R12: While reset is asserted and after it is released, the counter and all active, shadow, phase and mode registers are 0 and both PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 period, 1 compare A, 2 compare B, 3 phase, 4 mode |
| wr_data | input | W | Write data; mode uses bits 4:0 |
| sync_in | input | 1 | Sync pulse from the upstream time base |
| pwm_a | output | 1 | Raw PWM output A |
| pwm_b | output | 1 | Raw PWM output B |
| zero_evt | output | 1 | High while the counter is 0 |
| sync_out | output | 1 | Sync pulse toward downstream time bases |

## Verification
The hardest situations to reach from the ports are those where a write or a sync pulse lands partway through a cycle. The counter is not visible, so the bench aligns itself on `zero_evt` and counts clocks to a known count before it writes or pulses `sync_in`. It then measures the distance to the next zero and the number of high clocks on `pwm_a`. That distance shows whether a period change was deferred or applied immediately, whether a shrink below the running count wrapped at once, and whether a phase load jumped the count.

// File: rtl/pwm_phase_timebase.sv
`timescale 1ns/1ps
module pwm_phase_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         sync_in,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         zero_evt,
  output logic         sync_out
);
  localparam logic [2:0] A_PRD = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_PHS = 3'd3, A_MODE = 3'd4;
  localparam int MB = 5;

  logic [W-1:0] cnt, prd_act, prd_sh, cmpa_act, cmpa_sh, cmpb_act, cmpb_sh, phase;
  logic [MB-1:0] mode;

  wire phase_en = mode[0];
  wire fwd      = mode[1];
  wire imm_prd  = mode[2];
  wire imm_a    = mode[3];
  wire imm_b    = mode[4];

  wire wr_prd  = wr_en && wr_addr == A_PRD;
  wire wr_cmpa = wr_en && wr_addr == A_CMPA;
  wire wr_cmpb = wr_en && wr_addr == A_CMPB;
  wire load    = phase_en && sync_in;

  assign zero_evt = cnt == '0;
  assign sync_out = fwd ? sync_in : zero_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh  <= '0;
      cmpa_sh <= '0;
      cmpb_sh <= '0;
      phase   <= '0;
      mode    <= '0;
    end else begin
      if (wr_prd)  prd_sh  <= wr_data;
      if (wr_cmpa) cmpa_sh <= wr_data;
      if (wr_cmpb) cmpb_sh <= wr_data;
      if (wr_en && wr_addr == A_PHS)  phase <= wr_data;
      if (wr_en && wr_addr == A_MODE) mode  <= wr_data[MB-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else begin
      if (wr_prd && imm_prd)      prd_act <= wr_data;
      else if (zero_evt && !imm_prd) prd_act <= prd_sh;
      if (wr_cmpa && imm_a)       cmpa_act <= wr_data;
      else if (zero_evt && !imm_a)   cmpa_act <= cmpa_sh;
      if (wr_cmpb && imm_b)       cmpb_act <= wr_data;
      else if (zero_evt && !imm_b)   cmpb_act <= cmpb_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= phase;
    else if (cnt >= prd_act) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
    end else begin
      if (cnt == cmpa_act) pwm_a <= 1'b0;
      else if (zero_evt)   pwm_a <= 1'b1;
      if (cnt == cmpb_act) pwm_b <= 1'b0;
      else if (zero_evt)   pwm_b <= 1'b1;
    end
  end

  a_r2_period_shadow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !imm_prd) |=> prd_act == $past(prd_sh));
  a_r3_cmpa_shadow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !imm_a) |=> cmpa_act == $past(cmpa_sh));
  a_r5_rise_only_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_a) |-> $past(cnt) == '0);
  a_r5_fall_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_b) |-> $past(cnt) == $past(cmpb_act));
  a_r9_phase_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(phase));
  a_r10_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_en && cnt < prd_act) |=> cnt == $past(cnt) + 1'b1);
  a_r11_wrap_at_or_above: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt >= prd_act) |=> zero_evt);
endmodule

// File: tb/tb_pwm_phase_timebase.sv
`timescale 1ns/1ps
module tb_pwm_phase_timebase;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sync_in = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_a, pwm_b, zero_evt, sync_out;

  int checks = 0, fails = 0, cyc = 0;
  int gap, hi_a, hi_b, zc, sbad;
  bit done = 1'b0;

  pwm_phase_timebase #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_evt(zero_evt), .sync_out(sync_out));

  always #2 clk = ~clk;

  // {period, cmp A, cmp B, expected A highs, expected B highs} per window of period+1 clocks
  localparam logic [39:0] VEC [6] = '{
    {8'd9,  8'd4,  8'd7,  8'd4,  8'd7},
    {8'd9,  8'd0,  8'd9,  8'd0,  8'd9},
    {8'd9,  8'd10, 8'd3,  8'd10, 8'd3},
    {8'd4,  8'd2,  8'd20, 8'd2,  8'd5},
    {8'd15, 8'd1,  8'd15, 8'd1,  8'd15},
    {8'd0,  8'd0,  8'd1,  8'd0,  8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    gap++;
    if (pwm_a) hi_a++;
    if (pwm_b) hi_b++;
    if (zero_evt) zc++;
    if (sync_out != zero_evt) sbad++;
  endtask

  task automatic clr();
    gap = 0; hi_a = 0; hi_b = 0; zc = 0; sbad = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic until_zero();
    do tick(); while (!zero_evt);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!pwm_a && !pwm_b, "R12 outputs low in reset", {pwm_a, pwm_b}, 0);
    chk(zero_evt && sync_out, "R12 counter zero in reset", {zero_evt, sync_out}, 3);
    rst_n = 1'b1;
    settle(5);
    chk(!pwm_a && !pwm_b && zero_evt, "R12 idle after reset", {pwm_a, pwm_b, zero_evt}, 1);

    // R1 R5 R6 R7: steady-state vectors in shadow master mode
    for (int v = 0; v < 6; v++) begin
      int p, ea, eb;
      p  = int'(VEC[v][39:32]);
      ea = int'(VEC[v][15:8]);
      eb = int'(VEC[v][7:0]);
      wr(3'd0, 16'(p));
      wr(3'd1, 16'(VEC[v][31:24]));
      wr(3'd2, 16'(VEC[v][23:16]));
      settle(50);
      clr();
      settle(p + 1);
      chk(hi_a == ea, "R5 R6 pwm_a highs", hi_a, ea);
      chk(hi_b == eb, "R5 R6 pwm_b highs", hi_b, eb);
      chk(zc == 1, "R1 one zero per period", zc, 1);
      chk(sbad == 0, "R7 master sync equals zero", sbad, 0);
    end

    // R2: deferred period change
    wr(3'd0, 16'd9);
    settle(30);
    until_zero(); clr();
    settle(3);
    wr(3'd0, 16'd4);
    until_zero();
    chk(gap == 10, "R2 current cycle keeps old period", gap, 10);
    clr(); until_zero();
    chk(gap == 5, "R2 new period after zero", gap, 5);

    // R3: deferred compare change
    wr(3'd0, 16'd19);
    wr(3'd1, 16'd10);
    settle(50);
    until_zero(); clr();
    settle(2);
    wr(3'd1, 16'd5);
    until_zero();
    chk(hi_a == 10, "R3 current cycle keeps old compare", hi_a, 10);
    clr(); until_zero();
    chk(hi_a == 5, "R3 new compare after zero", hi_a, 5);

    // R4: immediate compare A
    wr(3'd4, 16'h0008);
    until_zero(); clr();
    wr(3'd1, 16'd12);
    until_zero();
    chk(hi_a == 12, "R4 immediate compare in current cycle", hi_a, 12);

    // R4 R11: immediate period, shrink below running count
    wr(3'd4, 16'h0004);
    wr(3'd0, 16'd9);
    settle(30);
    until_zero(); clr();
    settle(7);
    wr(3'd0, 16'd3);
    until_zero();
    chk(gap == 9, "R11 wrap when count above new period", gap, 9);
    clr(); until_zero();
    chk(gap == 4, "R4 immediate period in effect", gap, 4);

    // R8 R9: forwarding slave with phase load
    wr(3'd4, 16'h0003);
    wr(3'd0, 16'd19);
    wr(3'd3, 16'd7);
    settle(50);
    until_zero();
    chk(sync_out == 1'b0, "R8 no sync at zero in forward mode", sync_out, 0);
    clr();
    settle(3);
    sync_in = 1'b1;
    #1;
    chk(sync_out == 1'b1, "R8 sync forwarded", sync_out, 1);
    tick();
    sync_in = 1'b0;
    #1;
    chk(sync_out == 1'b0, "R8 sync low follows input", sync_out, 0);
    until_zero();
    chk(gap == 17, "R9 counter jumped to phase", gap, 17);

    // R10: phase loading disabled
    wr(3'd4, 16'h0002);
    settle(30);
    until_zero(); clr();
    settle(3);
    sync_in = 1'b1;
    tick();
    sync_in = 1'b0;
    until_zero();
    chk(gap == 20, "R10 sync ignored by counter", gap, 20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule